// File: doc/BRIEF.md
# SCSI Controller Host Register and Interrupt Block

This block is the host-side register file of a SCSI bus controller. A host reads and writes sixteen byte-wide offsets. Several offsets have one meaning when read and another when written: the host writes the target bus ID and the selection timeout at the same offsets where it reads status and interrupt cause. The block decodes command bytes. It keeps the status, interrupt-cause, sequence-step and FIFO-flag registers, and it drives a level-sensitive interrupt line.

Commands that need the bus engine (transfer, select with attention with or without stop, initiator command complete, message accepted) leave as one-cycle strobes. The engine reports its result on a completion port. That port loads status, cause, step and flags in one cycle and raises the interrupt. The block answers some commands on its own: flush, bus reset, enable selection, chip reset, and a selection of a target that a presence bitmap marks as absent.

The host clears the interrupt by reading the cause register. That read also clears the two error bits in status. A configuration bit can keep a bus reset from interrupting. Command codes not in the command set are refused and latch a sticky flag.

Top module: `scsi_host_regs`

## Requirements
- R1: After an asynchronous reset or a chip reset, every offset reads as follows: status 0x00, cause 0x00, step 0x00, flags 0x00, command readback 0x00, config 2 and config 3 0x00, config 1 (offset 0x8) CFG1_RST (0x07), ID register (offset 0xE) CHIP_ID (0x04), unmapped offsets (0x0-0x2, 0x9, 0xA, 0xD, 0xF) 0x00. After the same resets irq is low and the illegal flag is low.
- R2: Writes to 0x4 load the target bus ID (low ID_W bits, on bus_id_o), and writes to 0x5 load the selection timeout (sel_timeout_o); reads at 0x4 and 0x5 still return status and cause. Offsets 0x8, 0xB, 0xC and 0xE read back what was written. Writes to 0x6, 0x7 and to unmapped offsets change nothing.
- R3: Bit 7 of the status read (offset 0x4) always equals irq_o; bits 6:0 are the stored status.
- R4: A read of offset 0x5 returns the cause. From the next cycle irq is low and status bits 6 (gross error) and 5 (parity error) are clear. The cause and the other status bits stay as they were.
- R5: A cycle with done_valid loads status bits 6:0, cause, step and flags from the completion port and raises irq in the next cycle.
- R6: Command 0x03 (bus reset) sets the cause to 0x80. It raises irq only if bit 6 of config 1 is 0.
- R7: Command 0x01 (flush) sets the cause to 0x08 (function complete) and clears step and flags. It does not change irq.
- R8: Command 0x44 (enable selection) clears the cause. Command 0x12 (message accepted) sets the cause to 0x20 (disconnect), clears the step and pulses msg_acc_go.
- R9: Commands are decoded on bits 6:0. The codes 0x10, 0x11, 0x42 (target present) and 0x43 (target present) pulse xfer_go, icc_go, sel_go and sel_stop_go respectively. Each pulse is high for exactly the one cycle after the write. Command readback holds the full byte, and dma_o is its bit 7.
- R10: When 0x42 or 0x43 names a bus ID whose bit in target_present is 0, no strobe fires. Status becomes 0, the cause becomes 0x20, the step becomes 0, flags are unchanged and irq rises.
- R11: Command 0x02 (chip reset) restores the R1 values in both register banks and lowers irq, even when done_valid arrives in the same cycle.
- R12: A command code outside {0x00, 0x01, 0x02, 0x03, 0x10, 0x11, 0x12, 0x1A, 0x42, 0x43, 0x44} sets the sticky illegal_cmd_o. It leaves the command readback and all other state unchanged. Codes 0x00 and 0x1A update only the command readback.
- R13: An interrupt-raising event in the same cycle as a cause read leaves irq high. The completion's status error bits then survive that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register offset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (read side effects apply at the clock edge) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational from state) |
| irq_o | output | 1 | Level interrupt |
| target_present | input | 2**ID_W | One bit per bus ID: device attached |
| done_valid | input | 1 | Completion from the bus engine |
| done_status | input | 7 | Completion status bits 6:0 |
| done_cause | input | 8 | Completion interrupt cause |
| done_step | input | 8 | Completion sequence step |
| done_flags | input | 8 | Completion FIFO flags |
| xfer_go | output | 1 | Transfer strobe |
| icc_go | output | 1 | Initiator command complete strobe |
| msg_acc_go | output | 1 | Message accepted strobe |
| sel_go | output | 1 | Select with attention strobe |
| sel_stop_go | output | 1 | Select with attention and stop strobe |
| dma_o | output | 1 | DMA bit of the last accepted command |
| bus_id_o | output | ID_W | Target bus ID register |
| sel_timeout_o | output | 8 | Selection timeout register |
| illegal_cmd_o | output | 1 | Sticky illegal-command flag |

## Verification
The bench builds the block with ID_W = 3, so eight targets are addressable. Only target 5 is marked present, so one bench run drives selection down both the strobe path and the local no-device path. The reset values CFG1_RST = 0x07 and CHIP_ID = 0x04 are the defaults. The bench compares against them after the asynchronous reset and again after a chip-reset command issued together with a completion. The bench holds config 1 both with bit 6 clear and with it set, which reaches both outcomes of the bus-reset interrupt mask.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;

  localparam int DW = 8;
  localparam int AW = 4;

  // Register offsets (read bank / write bank share some of these)
  localparam logic [AW-1:0] OFS_CMD    = 4'h3;
  localparam logic [AW-1:0] OFS_STAT   = 4'h4;  // read: status, write: bus ID
  localparam logic [AW-1:0] OFS_CAUSE  = 4'h5;  // read: cause,  write: selection timeout
  localparam logic [AW-1:0] OFS_STEP   = 4'h6;
  localparam logic [AW-1:0] OFS_FLAGS  = 4'h7;
  localparam logic [AW-1:0] OFS_CFG1   = 4'h8;
  localparam logic [AW-1:0] OFS_CFG2   = 4'hB;
  localparam logic [AW-1:0] OFS_CFG3   = 4'hC;
  localparam logic [AW-1:0] OFS_CHIPID = 4'hE;

  // Command codes (bits 6:0 of the command byte)
  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_FLUSH    = 7'h01;
  localparam logic [6:0] OP_CHIPRST  = 7'h02;
  localparam logic [6:0] OP_BUSRST   = 7'h03;
  localparam logic [6:0] OP_XFER     = 7'h10;
  localparam logic [6:0] OP_ICC      = 7'h11;
  localparam logic [6:0] OP_MSGACC   = 7'h12;
  localparam logic [6:0] OP_SETATN   = 7'h1A;
  localparam logic [6:0] OP_SELATN   = 7'h42;
  localparam logic [6:0] OP_SELSTOP  = 7'h43;
  localparam logic [6:0] OP_ENSEL    = 7'h44;

  // Interrupt cause values
  localparam logic [DW-1:0] CAUSE_FUNC_DONE = 8'h08;
  localparam logic [DW-1:0] CAUSE_DISCON    = 8'h20;
  localparam logic [DW-1:0] CAUSE_BUS_RST   = 8'h80;

  // Status bit positions
  localparam int STAT_GROSS_ERR  = 6;
  localparam int STAT_PARITY_ERR = 5;
  // Config 1 bit that masks the bus-reset interrupt
  localparam int CFG1_RST_MASK   = 6;

  // Strobe vector positions
  localparam int SB_XFER   = 0;
  localparam int SB_ICC    = 1;
  localparam int SB_SEL    = 2;
  localparam int SB_SELSTP = 3;
  localparam int SB_MSGACC = 4;
  localparam int SB_N      = 5;

  typedef struct packed {
    logic nop;
    logic flush;
    logic chip_rst;
    logic bus_rst;
    logic xfer;
    logic icc;
    logic msg_acc;
    logic set_atn;
    logic sel_atn;
    logic sel_stop;
    logic en_sel;
    logic illegal;
  } cmd_dec_t;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_regs_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [6:0] code,
  output cmd_dec_t   dec
);

  always_comb begin
    dec = '0;
    if (cmd_wr) begin
      case (code)
        OP_NOP:     dec.nop      = 1'b1;
        OP_FLUSH:   dec.flush    = 1'b1;
        OP_CHIPRST: dec.chip_rst = 1'b1;
        OP_BUSRST:  dec.bus_rst  = 1'b1;
        OP_XFER:    dec.xfer     = 1'b1;
        OP_ICC:     dec.icc      = 1'b1;
        OP_MSGACC:  dec.msg_acc  = 1'b1;
        OP_SETATN:  dec.set_atn  = 1'b1;
        OP_SELATN:  dec.sel_atn  = 1'b1;
        OP_SELSTOP: dec.sel_stop = 1'b1;
        OP_ENSEL:   dec.en_sel   = 1'b1;
        default:    dec.illegal  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/scsi_tgt_lookup.sv
module scsi_tgt_lookup #(
  parameter int ID_W = 3
) (
  input  logic [ID_W-1:0]      id,
  input  logic [(1<<ID_W)-1:0] present,
  output logic                 hit
);

  localparam int NUM_TGT = 1 << ID_W;

  logic [NUM_TGT-1:0] match;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    assign match[g] = present[g] && (id == ID_W'(g));
  end

  assign hit = |match;

endmodule

// File: rtl/scsi_irq_ctl.sv
module scsi_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic force_low,
  input  logic raise,
  input  logic lower,
  output logic irq_o
);

  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (force_low)  irq_d = 1'b0;
    else if (raise) irq_d = 1'b1;
    else if (lower) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  a_r11_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |=> !irq_o);

  a_r13_raise_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (raise && !force_low) |=> irq_o);

  a_r4_read_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (lower && !raise && !force_low) |=> !irq_o);

  a_r3_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!lower && !raise && !force_low) |=> $stable(irq_o));

endmodule

// File: rtl/scsi_host_regs.sv
module scsi_host_regs
  import scsi_regs_pkg::*;
#(
  parameter int          ID_W     = 3,
  parameter logic [7:0]  CFG1_RST = 8'h07,
  parameter logic [7:0]  CHIP_ID  = 8'h04
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           host_addr,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  output logic                 irq_o,
  input  logic [(1<<ID_W)-1:0] target_present,
  input  logic                 done_valid,
  input  logic [6:0]           done_status,
  input  logic [7:0]           done_cause,
  input  logic [7:0]           done_step,
  input  logic [7:0]           done_flags,
  output logic                 xfer_go,
  output logic                 icc_go,
  output logic                 msg_acc_go,
  output logic                 sel_go,
  output logic                 sel_stop_go,
  output logic                 dma_o,
  output logic [ID_W-1:0]      bus_id_o,
  output logic [7:0]           sel_timeout_o,
  output logic                 illegal_cmd_o
);

  // ---------------------------------------------------------------- state
  logic [DW-1:0]   cmd_q,    cmd_d;
  logic [6:0]      stat_q,   stat_d;
  logic [DW-1:0]   cause_q,  cause_d;
  logic [DW-1:0]   step_q,   step_d;
  logic [DW-1:0]   flags_q,  flags_d;
  logic [DW-1:0]   cfg1_q,   cfg1_d;
  logic [DW-1:0]   cfg2_q,   cfg2_d;
  logic [DW-1:0]   cfg3_q,   cfg3_d;
  logic [DW-1:0]   chipid_q, chipid_d;
  logic [ID_W-1:0] busid_q,  busid_d;
  logic [DW-1:0]   selto_q,  selto_d;
  logic            illegal_q, illegal_d;
  logic [SB_N-1:0] strobe_q, strobe_d;

  // ---------------------------------------------------------------- decode
  logic     wr_cmd;
  logic     rd_cause;
  cmd_dec_t dec;
  logic     tgt_hit;
  logic     irq_raise;

  assign wr_cmd   = host_wr && (host_addr == OFS_CMD);
  assign rd_cause = host_rd && (host_addr == OFS_CAUSE);

  scsi_cmd_decode u_dec (
    .cmd_wr (wr_cmd),
    .code   (host_wdata[6:0]),
    .dec    (dec)
  );

  scsi_tgt_lookup #(.ID_W(ID_W)) u_tgt (
    .id      (busid_q),
    .present (target_present),
    .hit     (tgt_hit)
  );

  logic sel_any;
  logic sel_miss;
  logic busrst_irq;

  assign sel_any    = dec.sel_atn || dec.sel_stop;
  assign sel_miss   = sel_any && !tgt_hit;
  assign busrst_irq = dec.bus_rst && !cfg1_q[CFG1_RST_MASK];
  assign irq_raise  = done_valid || busrst_irq || sel_miss;

  scsi_irq_ctl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_low (dec.chip_rst),
    .raise     (irq_raise),
    .lower     (rd_cause),
    .irq_o     (irq_o)
  );

  // ---------------------------------------------------------------- next state
  always_comb begin
    cmd_d     = cmd_q;
    stat_d    = stat_q;
    cause_d   = cause_q;
    step_d    = step_q;
    flags_d   = flags_q;
    cfg1_d    = cfg1_q;
    cfg2_d    = cfg2_q;
    cfg3_d    = cfg3_q;
    chipid_d  = chipid_q;
    busid_d   = busid_q;
    selto_d   = selto_q;
    illegal_d = illegal_q;
    strobe_d  = '0;

    // read side effect on the cause register
    if (rd_cause) begin
      stat_d[STAT_GROSS_ERR]  = 1'b0;
      stat_d[STAT_PARITY_ERR] = 1'b0;
    end

    // completion from the bus engine
    if (done_valid) begin
      stat_d  = done_status;
      cause_d = done_cause;
      step_d  = done_step;
      flags_d = done_flags;
    end

    // plain register writes (write bank)
    if (host_wr) begin
      case (host_addr)
        OFS_STAT:   busid_d  = host_wdata[ID_W-1:0];
        OFS_CAUSE:  selto_d  = host_wdata;
        OFS_CFG1:   cfg1_d   = host_wdata;
        OFS_CFG2:   cfg2_d   = host_wdata;
        OFS_CFG3:   cfg3_d   = host_wdata;
        OFS_CHIPID: chipid_d = host_wdata;
        default: ;
      endcase
    end

    // command effects
    if (dec.illegal) begin
      illegal_d = 1'b1;
    end else if (wr_cmd) begin
      cmd_d = host_wdata;
    end

    if (dec.flush) begin
      cause_d = CAUSE_FUNC_DONE;
      step_d  = '0;
      flags_d = '0;
    end

    if (dec.bus_rst) begin
      cause_d = CAUSE_BUS_RST;
    end

    if (dec.xfer) strobe_d[SB_XFER] = 1'b1;
    if (dec.icc)  strobe_d[SB_ICC]  = 1'b1;

    if (dec.msg_acc) begin
      strobe_d[SB_MSGACC] = 1'b1;
      cause_d             = CAUSE_DISCON;
      step_d              = '0;
    end

    if (dec.en_sel) begin
      cause_d = '0;
    end

    if (sel_any) begin
      if (tgt_hit) begin
        strobe_d[SB_SEL]    = dec.sel_atn;
        strobe_d[SB_SELSTP] = dec.sel_stop;
      end else begin
        stat_d  = '0;
        cause_d = CAUSE_DISCON;
        step_d  = '0;
      end
    end

    // chip reset overrides everything in the cycle
    if (dec.chip_rst) begin
      cmd_d     = '0;
      stat_d    = '0;
      cause_d   = '0;
      step_d    = '0;
      flags_d   = '0;
      cfg1_d    = CFG1_RST;
      cfg2_d    = '0;
      cfg3_d    = '0;
      chipid_d  = CHIP_ID;
      busid_d   = '0;
      selto_d   = '0;
      illegal_d = 1'b0;
      strobe_d  = '0;
    end
  end

  // ---------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      stat_q    <= '0;
      cause_q   <= '0;
      step_q    <= '0;
      flags_q   <= '0;
      cfg1_q    <= CFG1_RST;
      cfg2_q    <= '0;
      cfg3_q    <= '0;
      chipid_q  <= CHIP_ID;
      busid_q   <= '0;
      selto_q   <= '0;
      illegal_q <= 1'b0;
      strobe_q  <= '0;
    end else begin
      cmd_q     <= cmd_d;
      stat_q    <= stat_d;
      cause_q   <= cause_d;
      step_q    <= step_d;
      flags_q   <= flags_d;
      cfg1_q    <= cfg1_d;
      cfg2_q    <= cfg2_d;
      cfg3_q    <= cfg3_d;
      chipid_q  <= chipid_d;
      busid_q   <= busid_d;
      selto_q   <= selto_d;
      illegal_q <= illegal_d;
      strobe_q  <= strobe_d;
    end
  end

  // ---------------------------------------------------------------- read bank
  always_comb begin
    case (host_addr)
      OFS_CMD:    host_rdata = cmd_q;
      OFS_STAT:   host_rdata = {irq_o, stat_q};
      OFS_CAUSE:  host_rdata = cause_q;
      OFS_STEP:   host_rdata = step_q;
      OFS_FLAGS:  host_rdata = flags_q;
      OFS_CFG1:   host_rdata = cfg1_q;
      OFS_CFG2:   host_rdata = cfg2_q;
      OFS_CFG3:   host_rdata = cfg3_q;
      OFS_CHIPID: host_rdata = chipid_q;
      default:    host_rdata = '0;
    endcase
  end

  assign xfer_go       = strobe_q[SB_XFER];
  assign icc_go        = strobe_q[SB_ICC];
  assign sel_go        = strobe_q[SB_SEL];
  assign sel_stop_go   = strobe_q[SB_SELSTP];
  assign msg_acc_go    = strobe_q[SB_MSGACC];
  assign dma_o         = cmd_q[7];
  assign bus_id_o      = busid_q;
  assign sel_timeout_o = selto_q;
  assign illegal_cmd_o = illegal_q;

  // ---------------------------------------------------------------- assertions
  a_r3_flag_mirrors_line: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_STAT) |-> (host_rdata[7] == irq_o));

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_go, icc_go, sel_go, sel_stop_go, msg_acc_go}));

  a_r12_decode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |-> $onehot(dec));

  a_r9_xfer_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && host_wdata[6:0] == OP_XFER) |=> (xfer_go && !icc_go));

  a_r10_absent_target: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_any && !tgt_hit) |=> (!sel_go && !sel_stop_go && irq_o
                               && cause_q == CAUSE_DISCON && stat_q == 7'd0));

  a_r12_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_cmd_o && !dec.chip_rst) |=> illegal_cmd_o);

  a_r12_illegal_keeps_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    dec.illegal |=> (illegal_cmd_o && $stable(cmd_q)));

  a_r11_chip_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    dec.chip_rst |=> (cfg1_q == CFG1_RST && chipid_q == CHIP_ID
                      && !illegal_cmd_o && !irq_o && cause_q == 8'h00));

  a_r6_bus_reset_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.bus_rst && cfg1_q[CFG1_RST_MASK] && !irq_o && !done_valid) |=> !irq_o);

endmodule

// File: tb/scsi_host_regs_bench.sv
`timescale 1ns/1ps
module scsi_host_regs_bench;

  localparam int ID_W = 3;

  logic                 clk;
  logic                 rst_n;
  logic [3:0]           host_addr;
  logic                 host_wr;
  logic                 host_rd;
  logic [7:0]           host_wdata;
  logic [7:0]           host_rdata;
  logic                 irq_o;
  logic [(1<<ID_W)-1:0] target_present;
  logic                 done_valid;
  logic [6:0]           done_status;
  logic [7:0]           done_cause;
  logic [7:0]           done_step;
  logic [7:0]           done_flags;
  logic                 xfer_go, icc_go, msg_acc_go, sel_go, sel_stop_go, dma_o;
  logic [ID_W-1:0]      bus_id_o;
  logic [7:0]           sel_timeout_o;
  logic                 illegal_cmd_o;

  scsi_host_regs #(.ID_W(ID_W), .CFG1_RST(8'h07), .CHIP_ID(8'h04)) u_scsi_host_regs (
    .clk, .rst_n, .host_addr, .host_wr, .host_rd, .host_wdata, .host_rdata,
    .irq_o, .target_present, .done_valid, .done_status, .done_cause,
    .done_step, .done_flags, .xfer_go, .icc_go, .msg_acc_go, .sel_go,
    .sel_stop_go, .dma_o, .bus_id_o, .sel_timeout_o, .illegal_cmd_o
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------------------------------------------------------- scoreboard
  localparam int K_RDATA = 0, K_IRQ = 1, K_STRB = 2, K_ILL = 3, K_BUSID = 4,
                 K_DMA = 5, K_SELTO = 6;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;

  task automatic push(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    exp_q.push_back(it);
  endtask

  // monitor: samples two time units after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        item_t      it;
        logic [7:0] act;
        it = exp_q.pop_front();
        case (it.kind)
          K_RDATA: act = host_rdata;
          K_IRQ:   act = {7'd0, irq_o};
          K_STRB:  act = {3'd0, msg_acc_go, sel_stop_go, sel_go, icc_go, xfer_go};
          K_ILL:   act = {7'd0, illegal_cmd_o};
          K_BUSID: act = {5'd0, bus_id_o};
          K_DMA:   act = {7'd0, dma_o};
          default: act = sel_timeout_o;
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: kind %0d actual %02h expected %02h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  // ---------------------------------------------------------------- driver
  task automatic drive(input bit wr, input bit rd, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr    = wr;
    host_rd    = rd;
    host_addr  = a;
    host_wdata = d;
    done_valid = 1'b0;
  endtask

  task automatic idle();
    drive(0, 0, 4'h0, 8'h00);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    drive(1, 0, a, d);
  endtask

  task automatic rchk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    drive(0, 1, a, 8'h00);
    push(K_RDATA, exp, tag);
  endtask

  task automatic complete(input logic [6:0] st, input logic [7:0] ca,
                          input logic [7:0] sp, input logic [7:0] fl);
    drive(0, 0, 4'h0, 8'h00);
    done_valid  = 1'b1;
    done_status = st;
    done_cause  = ca;
    done_step   = sp;
    done_flags  = fl;
  endtask

  // ---------------------------------------------------------------- watchdog
  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------------------------------------------------------- stimulus
  initial begin
    rst_n = 1'b0;
    host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
    done_valid = 0; done_status = '0; done_cause = '0; done_step = '0; done_flags = '0;
    target_present = 8'b0010_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    idle(); push(K_IRQ, 0, "R1 irq"); push(K_ILL, 0, "R1 illegal"); push(K_STRB, 0, "R1 strobes");
    rchk(4'h4, 8'h00, "R1 status");
    rchk(4'h5, 8'h00, "R1 cause");
    rchk(4'h6, 8'h00, "R1 step");
    rchk(4'h7, 8'h00, "R1 flags");
    rchk(4'h3, 8'h00, "R1 cmd");
    rchk(4'h8, 8'h07, "R1 cfg1");
    rchk(4'hB, 8'h00, "R1 cfg2");
    rchk(4'hC, 8'h00, "R1 cfg3");
    rchk(4'hE, 8'h04, "R1 chip id");
    rchk(4'h0, 8'h00, "R1 unmapped 0");
    rchk(4'hF, 8'h00, "R1 unmapped F");

    // R2 split banks
    wreg(4'hB, 8'h5A); wreg(4'hC, 8'h3C); wreg(4'hE, 8'h9F);
    wreg(4'h4, 8'h05); wreg(4'h5, 8'hC8);
    wreg(4'h6, 8'hFF); wreg(4'h7, 8'hFF); wreg(4'h1, 8'h77);
    idle(); push(K_BUSID, 8'h05, "R2 bus id"); push(K_SELTO, 8'hC8, "R2 sel timeout");
    rchk(4'hB, 8'h5A, "R2 cfg2");
    rchk(4'hC, 8'h3C, "R2 cfg3");
    rchk(4'hE, 8'h9F, "R2 id reg");
    rchk(4'h4, 8'h00, "R2 status not bus id");
    rchk(4'h5, 8'h00, "R2 cause not timeout");
    rchk(4'h6, 8'h00, "R2 step read-only");
    rchk(4'h7, 8'h00, "R2 flags read-only");
    rchk(4'h1, 8'h00, "R2 unmapped write");

    // R5 completion, R3 flag, R4 read clear
    complete(7'h61, 8'h18, 8'h04, 8'h02);
    idle(); push(K_IRQ, 1, "R5 irq raised");
    rchk(4'h4, 8'hE1, "R3 R5 status");
    rchk(4'h6, 8'h04, "R5 step");
    rchk(4'h7, 8'h02, "R5 flags");
    rchk(4'h5, 8'h18, "R4 cause read");
    idle(); push(K_IRQ, 0, "R4 irq lowered");
    rchk(4'h4, 8'h01, "R4 error bits cleared");
    rchk(4'h5, 8'h18, "R4 cause kept");

    // R6 bus reset
    wreg(4'h3, 8'h03);
    idle(); push(K_IRQ, 1, "R6 unmasked irq");
    rchk(4'h5, 8'h80, "R6 cause");
    wreg(4'h3, 8'h44);
    rchk(4'h5, 8'h00, "R8 enable selection");
    wreg(4'h8, 8'h47);
    wreg(4'h3, 8'h03);
    idle(); push(K_IRQ, 0, "R6 masked irq");
    rchk(4'h5, 8'h80, "R6 masked cause");
    rchk(4'h8, 8'h47, "R2 cfg1");
    wreg(4'h8, 8'h07);

    // R7 flush
    complete(7'h03, 8'h10, 8'h02, 8'h05);
    wreg(4'h3, 8'h01);
    idle(); push(K_IRQ, 1, "R7 irq unaffected");
    rchk(4'h4, 8'h83, "R7 status");
    rchk(4'h6, 8'h00, "R7 step");
    rchk(4'h7, 8'h00, "R7 flags");
    rchk(4'h5, 8'h08, "R7 cause");

    // R8 message accepted
    complete(7'h00, 8'h18, 8'h03, 8'h00);
    wreg(4'h3, 8'h12);
    idle(); push(K_STRB, 8'h10, "R8 msg strobe");
    rchk(4'h5, 8'h20, "R8 msg cause");
    rchk(4'h6, 8'h00, "R8 msg step");
    wreg(4'h3, 8'h44);
    rchk(4'h5, 8'h00, "R8 enable selection clears");

    // R9 strobes
    wreg(4'h3, 8'h90);
    idle(); push(K_STRB, 8'h01, "R9 xfer strobe"); push(K_DMA, 1, "R9 dma bit");
    idle(); push(K_STRB, 8'h00, "R9 single cycle");
    rchk(4'h3, 8'h90, "R9 cmd readback");
    wreg(4'h3, 8'h11);
    idle(); push(K_STRB, 8'h02, "R9 icc strobe"); push(K_DMA, 0, "R9 dma clear");
    wreg(4'h3, 8'h42);
    idle(); push(K_STRB, 8'h04, "R9 select strobe"); push(K_IRQ, 0, "R9 no irq");
    wreg(4'h3, 8'hC3);
    idle(); push(K_STRB, 8'h08, "R9 select stop strobe"); push(K_DMA, 1, "R9 dma select");

    // R10 absent target
    complete(7'h07, 8'h10, 8'h04, 8'h06);
    rchk(4'h5, 8'h10, "R4 pre-select read");
    wreg(4'h4, 8'h02);
    wreg(4'h3, 8'h43);
    idle(); push(K_STRB, 8'h00, "R10 no strobe"); push(K_IRQ, 1, "R10 irq");
    rchk(4'h4, 8'h80, "R10 status");
    rchk(4'h6, 8'h00, "R10 step");
    rchk(4'h7, 8'h06, "R10 flags kept");
    rchk(4'h5, 8'h20, "R10 cause");

    // R12 illegal command
    wreg(4'h3, 8'h55);
    idle(); push(K_ILL, 1, "R12 illegal set"); push(K_IRQ, 0, "R12 irq unchanged");
    push(K_STRB, 8'h00, "R12 no strobe");
    rchk(4'h3, 8'h43, "R12 cmd unchanged");
    rchk(4'h5, 8'h20, "R12 cause unchanged");
    wreg(4'h3, 8'h1A);
    idle(); push(K_ILL, 1, "R12 sticky");
    rchk(4'h3, 8'h1A, "R12 set attention readback");
    rchk(4'h5, 8'h20, "R12 set attention no effect");
    wreg(4'h3, 8'h00);
    rchk(4'h3, 8'h00, "R12 nop readback");

    // R13 raise during cause read
    drive(0, 1, 4'h5, 8'h00);
    done_valid = 1'b1; done_status = 7'h60; done_cause = 8'h10; done_step = 8'h01; done_flags = 8'h00;
    push(K_RDATA, 8'h20, "R13 old cause");
    idle(); push(K_IRQ, 1, "R13 irq stays");
    rchk(4'h4, 8'hE0, "R13 error bits survive");
    rchk(4'h5, 8'h10, "R13 new cause");
    idle(); push(K_IRQ, 0, "R4 irq lowered again");

    // R11 chip reset with completion in the same cycle
    wreg(4'hB, 8'h11);
    wreg(4'h5, 8'h33);
    wreg(4'h3, 8'h55);
    wreg(4'h3, 8'h02);
    done_valid = 1'b1; done_status = 7'h7F; done_cause = 8'hFF; done_step = 8'h07; done_flags = 8'h0F;
    idle(); push(K_IRQ, 0, "R11 irq low"); push(K_ILL, 0, "R11 illegal cleared");
    push(K_BUSID, 8'h00, "R11 bus id"); push(K_SELTO, 8'h00, "R11 sel timeout");
    rchk(4'h8, 8'h07, "R11 cfg1");
    rchk(4'hB, 8'h00, "R11 cfg2");
    rchk(4'hE, 8'h04, "R11 chip id");
    rchk(4'h4, 8'h00, "R11 status");
    rchk(4'h5, 8'h00, "R11 cause");
    rchk(4'h6, 8'h00, "R11 step");
    rchk(4'h7, 8'h00, "R11 flags");
    rchk(4'h3, 8'h00, "R11 cmd");

    // R1 asynchronous reset mid-run
    wreg(4'hB, 8'hAA);
    complete(7'h01, 8'h08, 8'h00, 8'h00);
    idle(); push(K_IRQ, 1, "R5 irq before reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    idle(); push(K_IRQ, 0, "R1 async irq");
    rchk(4'hB, 8'h00, "R1 async cfg2");
    rchk(4'h4, 8'h00, "R1 async status");

    repeat (3) idle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule